// File: doc/BRIEF.md
# Power-Fault Sleep Sequencer

This block is a small power-management controller for a low-power processor. It watches two active-low fault inputs. One reports a weak or missing main battery and the other reports a core supply that has left regulation. It also watches a wake-up request and an active-low hard-reset input. From these it drives an active-high enable to the core supply, a sleep indication, a reset indication and a one-cycle fault-exception flag. All durations are counted in pulses of a slow reference tick, which is a single-cycle enable at 32.768 kHz in the system clock domain. The default qualification window is 33 ticks (about 1 ms) and the default post-wake blanking window is 328 ticks (about 10 ms).

The asynchronous inputs (both faults, wake and hard reset) each pass through a two-flop synchroniser. The controller has five states. RUN is normal operation. SLEEP_ENTRY is a one-cycle power-down step. SLEEP holds the core unpowered. WAKE_SETTLE is the supply settling window after a wake. RESET holds the core in reset while hard reset is low. The transitions are:
- RUN→SLEEP_ENTRY on a qualified fault when sleep-on-fault is selected.
- SLEEP_ENTRY→SLEEP unconditionally.
- SLEEP→WAKE_SETTLE on a wake request while the battery is good.
- WAKE_SETTLE→RUN when the blanking timer expires.
- WAKE_SETTLE→SLEEP_ENTRY when the battery fault has been held for the full qualification window.
- any state→RESET while hard reset is low.
- RESET→RUN once hard reset is released.

Top module: `pfs_sleep_seq`

## Requirements
- R1: A battery fault held low for QUAL_TICKS consecutive ticks in RUN with `fault_sleep_en`=1 moves the block through SLEEP_ENTRY into SLEEP, and `sleep_ind` goes high.
- R2: A fault that stays low for fewer than QUAL_TICKS ticks is ignored: no exception pulse, and the block stays in RUN.
- R3: A supply fault held low for QUAL_TICKS ticks in RUN with `fault_sleep_en`=1 also leads into SLEEP.
- R4: A wake request is not honoured while the synchronised battery fault is low, and the block remains in SLEEP.
- R5: `pwr_en` is low in SLEEP_ENTRY and SLEEP and high in every other state. It returns high on the first cycle of WAKE_SETTLE.
- R6: The supply-fault qualifier is held cleared throughout WAKE_SETTLE, which lasts BLANK_TICKS ticks. Qualification of a supply fault starts only after the return to RUN.
- R7: Hard reset low forces RESET from any state, including SLEEP. In RESET, `reset_out`=1, `pwr_en`=1 and `sleep_ind`=0. Releasing hard reset returns the block to RUN.
- R8: `fault_exc` pulses for exactly one cycle when a qualified fault is accepted in RUN. With `fault_sleep_en`=0 the block stays in RUN.
- R9: A battery fault held for QUAL_TICKS ticks during WAKE_SETTLE sends the block back into SLEEP without an exception pulse.
- R10: While `rst_n` is low the block is in RESET. After `rst_n` is released it stays in RESET until the synchronised hard-reset input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_32k | input | 1 | Single-cycle slow reference tick enable |
| batt_fault_n | input | 1 | Asynchronous battery fault, active low |
| supply_fault_n | input | 1 | Asynchronous supply fault, active low |
| wake_req | input | 1 | Asynchronous wake-up request, active high |
| hard_reset_n | input | 1 | Asynchronous hard reset, active low |
| fault_sleep_en | input | 1 | 1: an accepted fault in RUN also enters sleep |
| pwr_en | output | 1 | Core supply enable |
| sleep_ind | output | 1 | High in SLEEP_ENTRY and SLEEP |
| reset_out | output | 1 | High in RESET |
| fault_exc | output | 1 | One-cycle pulse on an accepted fault in RUN |

## Verification
The hardest state to reach from the ports is a supply fault that is already present when the settling window ends. It has to be held through all 328 ticks of blanking and then qualified afresh in RUN. The bench gets there by waking the block, pulling the supply fault low straight away and holding it for well over 1,400 cycles. It checks that sleep has not been re-entered partway through, and that it has been re-entered once the blanking and qualification windows have both elapsed. A battery fault that arrives inside the settling window is reached the same way. The behavioural model follows every boundary cycle.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [2:0] {
        ST_RUN         = 3'd0,
        ST_SLEEP_ENTRY = 3'd1,
        ST_SLEEP       = 3'd2,
        ST_WAKE_SETTLE = 3'd3,
        ST_RESET       = 3'd4
    } pfs_state_e;

    localparam int FAULT_BATT   = 0;
    localparam int FAULT_SUPPLY = 1;
    localparam int NUM_FAULTS   = 2;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int          WIDTH     = 4,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pfs_fault_qual.sv
module pfs_fault_qual #(
    parameter int QUAL_TICKS = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic flt_act,
    input  logic clr,
    output logic hit,
    output logic held
);
    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);
    localparam logic [CW-1:0] FULL = CW'(QUAL_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !flt_act) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit  = !clr && flt_act && tick && (cnt_q == LAST);
    assign held = (cnt_q == FULL);

    AST_QUAL_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL); // R2
    AST_QUAL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || !flt_act) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/pfs_blank_timer.sv
module pfs_blank_timer #(
    parameter int BLANK_TICKS = 328
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(BLANK_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && tick && (cnt_q == LAST);

    AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R6
endmodule

// File: rtl/pfs_sleep_seq.sv
module pfs_sleep_seq
    import pfs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_TICKS  = 33,
    parameter int BLANK_TICKS = 328
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_32k,
    input  logic batt_fault_n,
    input  logic supply_fault_n,
    input  logic wake_req,
    input  logic hard_reset_n,
    input  logic fault_sleep_en,
    output logic pwr_en,
    output logic sleep_ind,
    output logic reset_out,
    output logic fault_exc
);
    // synchronised bit order: [3] hard reset, [2] wake, [1] supply_n, [0] batt_n
    logic [3:0] raw_in;
    logic [3:0] syn_in;
    logic       batt_act;
    logic       wake_s;
    logic       hrst_ok;

    logic [NUM_FAULTS-1:0] flt_act;
    logic [NUM_FAULTS-1:0] flt_clr;
    logic [NUM_FAULTS-1:0] flt_hit;
    logic [NUM_FAULTS-1:0] flt_held;

    logic       blank_done;
    pfs_state_e state_q, state_nx;
    logic       exc_nx;

    assign raw_in = {hard_reset_n, wake_req, supply_fault_n, batt_fault_n};

    pfs_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0011)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(raw_in),
        .q_sync (syn_in)
    );

    assign batt_act = !syn_in[0];
    assign wake_s   = syn_in[2];
    assign hrst_ok  = syn_in[3];

    assign flt_act[FAULT_BATT]   = !syn_in[0];
    assign flt_act[FAULT_SUPPLY] = !syn_in[1];
    assign flt_clr[FAULT_BATT]   = (state_q == ST_RESET);
    assign flt_clr[FAULT_SUPPLY] = (state_q == ST_RESET) || (state_q == ST_WAKE_SETTLE);

    for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_qual
        pfs_fault_qual #(
            .QUAL_TICKS(QUAL_TICKS)
        ) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_32k),
            .flt_act(flt_act[g]),
            .clr    (flt_clr[g]),
            .hit    (flt_hit[g]),
            .held   (flt_held[g])
        );
    end

    pfs_blank_timer #(
        .BLANK_TICKS(BLANK_TICKS)
    ) u_blank (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_32k),
        .run  (state_q == ST_WAKE_SETTLE),
        .done (blank_done)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        exc_nx   = 1'b0;
        if (!hrst_ok) begin
            state_nx = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    exc_nx = |flt_hit;
                    if (|flt_hit && fault_sleep_en) state_nx = ST_SLEEP_ENTRY;
                end
                ST_SLEEP_ENTRY: state_nx = ST_SLEEP;
                ST_SLEEP: begin
                    if (wake_s && !batt_act) state_nx = ST_WAKE_SETTLE;
                end
                ST_WAKE_SETTLE: begin
                    if (flt_held[FAULT_BATT]) state_nx = ST_SLEEP_ENTRY;
                    else if (blank_done)      state_nx = ST_RUN;
                end
                ST_RESET: state_nx = ST_RUN;
                default:  state_nx = ST_RESET;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RESET;
            fault_exc <= 1'b0;
        end else begin
            state_q   <= state_nx;
            fault_exc <= exc_nx;
        end
    end

    // outputs
    always_comb begin
        pwr_en    = 1'b1;
        sleep_ind = 1'b0;
        reset_out = 1'b0;
        unique case (state_q)
            ST_SLEEP_ENTRY, ST_SLEEP: begin
                pwr_en    = 1'b0;
                sleep_ind = 1'b1;
            end
            ST_RESET: reset_out = 1'b1;
            default: ;
        endcase
    end

    AST_ENTRY_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP_ENTRY) |=> (state_q == ST_SLEEP || state_q == ST_RESET)); // R1
    AST_NO_WAKE_BATT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && batt_act) |=> (state_q != ST_WAKE_SETTLE)); // R4
    AST_RESET_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !hrst_ok |=> (state_q == ST_RESET)); // R7
    AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_exc |=> !fault_exc); // R8
    AST_SUPPLY_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE_SETTLE && $past(state_q) == ST_WAKE_SETTLE)
            |-> !flt_held[FAULT_SUPPLY]); // R6
    AST_PWR_DURING_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE_SETTLE) |-> pwr_en); // R5
endmodule

// File: tb/test_pfs_sleep_seq.sv
module test_pfs_sleep_seq;
    localparam int QUAL  = 33;
    localparam int BLANK = 328;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_32k = 1'b0;
    logic batt_fault_n = 1'b1;
    logic supply_fault_n = 1'b1;
    logic wake_req = 1'b0;
    logic hard_reset_n = 1'b1;
    logic fault_sleep_en = 1'b1;
    logic pwr_en, sleep_ind, reset_out, fault_exc;

    int checks = 0;
    int failures = 0;
    int exc_seen = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pfs_sleep_seq i_pfs_sleep_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_32k      (tick_32k),
        .batt_fault_n  (batt_fault_n),
        .supply_fault_n(supply_fault_n),
        .wake_req      (wake_req),
        .hard_reset_n  (hard_reset_n),
        .fault_sleep_en(fault_sleep_en),
        .pwr_en        (pwr_en),
        .sleep_ind     (sleep_ind),
        .reset_out     (reset_out),
        .fault_exc     (fault_exc)
    );

    // slow tick: one cycle in four
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        tick_32k <= (tick_div == 0);
    end

    // behavioural reference model: 0 run, 1 entry, 2 sleep, 3 settle, 4 reset
    int  m_st = 4;
    int  m_bcnt = 0, m_vcnt = 0, m_blank = 0;
    bit  m_exc = 0;
    bit  b1 = 1, b2 = 1, v1 = 1, v2 = 1, w1 = 0, w2 = 0, h1 = 0, h2 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 4; m_bcnt = 0; m_vcnt = 0; m_blank = 0; m_exc = 0;
            b1 = 1; b2 = 1; v1 = 1; v2 = 1; w1 = 0; w2 = 0; h1 = 0; h2 = 0;
        end else begin
            bit bf, vf, bclr, vclr, bhit, vhit, bheld, bdone;
            int nst;
            bf = !b2; vf = !v2;
            bclr = (m_st == 4);
            vclr = (m_st == 4) || (m_st == 3);
            bhit = !bclr && bf && tick_32k && (m_bcnt == QUAL - 1);
            vhit = !vclr && vf && tick_32k && (m_vcnt == QUAL - 1);
            bheld = (m_bcnt == QUAL);
            bdone = (m_st == 3) && tick_32k && (m_blank == BLANK - 1);
            nst = m_st;
            m_exc = 0;
            if (!h2) nst = 4;
            else if (m_st == 0) begin
                m_exc = bhit || vhit;
                if ((bhit || vhit) && fault_sleep_en) nst = 1;
            end
            else if (m_st == 1) nst = 2;
            else if (m_st == 2) begin if (w2 && !bf) nst = 3; end
            else if (m_st == 3) begin
                if (bheld) nst = 1; else if (bdone) nst = 0;
            end
            else nst = 0;
            if (bclr || !bf) m_bcnt = 0; else if (tick_32k && m_bcnt < QUAL) m_bcnt++;
            if (vclr || !vf) m_vcnt = 0; else if (tick_32k && m_vcnt < QUAL) m_vcnt++;
            if (m_st != 3) m_blank = 0; else if (tick_32k && m_blank < BLANK - 1) m_blank++;
            m_st = nst;
            b2 = b1; b1 = batt_fault_n; v2 = v1; v1 = supply_fault_n;
            w2 = w1; w1 = wake_req; h2 = h1; h1 = hard_reset_n;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_pwr, e_slp, e_rst;
            e_slp = (m_st == 1) || (m_st == 2);
            e_pwr = !e_slp;
            e_rst = (m_st == 4);
            checks++;
            if (pwr_en !== e_pwr) begin
                failures++; $display("FAIL R5 pwr_en act=%0b exp=%0b t=%0t", pwr_en, e_pwr, $time);
            end
            if (sleep_ind !== e_slp) begin
                failures++; $display("FAIL R1 sleep_ind act=%0b exp=%0b t=%0t", sleep_ind, e_slp, $time);
            end
            if (reset_out !== e_rst) begin
                failures++; $display("FAIL R7 reset_out act=%0b exp=%0b t=%0t", reset_out, e_rst, $time);
            end
            if (fault_exc !== m_exc) begin
                failures++; $display("FAIL R8 fault_exc act=%0b exp=%0b t=%0t", fault_exc, m_exc, $time);
            end
            if (fault_exc === 1'b1) exc_seen++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10: reset state
        cyc(3);
        chk("R10 reset_out in reset", reset_out, 1);
        chk("R10 pwr_en in reset", pwr_en, 1);
        chk("R10 sleep_ind in reset", sleep_ind, 0);
        rst_n = 1'b1;
        cyc(6);
        chk("R10 left reset", reset_out, 0);

        // R2: short battery pulse ignored
        batt_fault_n = 1'b0; cyc(80); batt_fault_n = 1'b1; cyc(200);
        chk("R2 no sleep on short pulse", sleep_ind, 0);
        chk("R2 no exception on short pulse", exc_seen, 0);

        // R1: qualified battery fault -> sleep
        batt_fault_n = 1'b0; cyc(160);
        chk("R1 sleep after battery fault", sleep_ind, 1);
        chk("R5 pwr_en low in sleep", pwr_en, 0);
        chk("R8 one exception", exc_seen, 1);

        // R4: wake locked out while battery low
        wake_req = 1'b1; cyc(4); wake_req = 1'b0; cyc(20);
        chk("R4 wake ignored with battery low", sleep_ind, 1);

        // R5: wake with battery good
        batt_fault_n = 1'b1; cyc(10);
        wake_req = 1'b1; cyc(4); wake_req = 1'b0; cyc(6);
        chk("R5 pwr_en high in settle", pwr_en, 1);
        chk("R5 sleep_ind low in settle", sleep_ind, 0);

        // R6 / R3: supply fault blanked, then qualified in run
        supply_fault_n = 1'b0; cyc(200);
        chk("R6 supply fault blanked", sleep_ind, 0);
        cyc(1000);
        chk("R6 still blanked near window end", sleep_ind, 0);
        cyc(600);
        chk("R3 sleep after supply fault", sleep_ind, 1);
        chk("R8 second exception", exc_seen, 2);

        // R9: battery fault during settle
        supply_fault_n = 1'b1; cyc(10);
        wake_req = 1'b1; cyc(4); wake_req = 1'b0; cyc(10);
        chk("R9 in settle", sleep_ind, 0);
        batt_fault_n = 1'b0; cyc(160);
        chk("R9 back to sleep", sleep_ind, 1);
        chk("R9 no exception", exc_seen, 2);

        // R7: hard reset from sleep
        batt_fault_n = 1'b1; cyc(10);
        hard_reset_n = 1'b0; cyc(6);
        chk("R7 reset_out in hard reset", reset_out, 1);
        chk("R7 pwr_en in hard reset", pwr_en, 1);
        chk("R7 sleep left", sleep_ind, 0);
        hard_reset_n = 1'b1; cyc(6);
        chk("R7 back to run", reset_out, 0);

        // R8: exception only, mode off
        fault_sleep_en = 1'b0;
        supply_fault_n = 1'b0; cyc(200);
        chk("R8 stays in run", sleep_ind, 0);
        chk("R8 third exception", exc_seen, 3);
        supply_fault_n = 1'b1; cyc(20);

        finish_run();
    end
endmodule